// File: doc/BRIEF.md
# Bus-Programmed Watchdog Timer with Staged Response

The block is a watchdog peripheral on an APB slave port. A down-counter runs while the watchdog is enabled. Software must keep reloading it by writing a fixed key to a restart register. If the counter reaches zero, the watchdog either requests a system reset at once or first raises an interrupt and requests the reset only when the next expiry comes. The reset request is a pulse whose length is a programmable power of two.

A separate start-up period is loaded when the watchdog is switched on. It applies only until the first restart or the first expiry, so boot code can be given more time than the steady-state service loop. An external pause input freezes the counter, for example while a debugger halts the system. A build parameter can force the watchdog on from reset, and software then cannot switch it off.

Periods are powers of two. A 4-bit selector `c` gives a load value of 2^(PERIOD_BASE+c) clocks. The reset-request pulse selector `p` gives 2^(p+1) clocks.

Top module: `wdt_apb`

## Requirements
- R1: Every APB access completes in its access phase: `pready` is 1 and `pslverr` is 0. The control word at offset 0x00 reads back with enable in bit 0, response mode in bit 1 and pulse selector in bits 4:2. The period word at 0x04 reads back with the running-period selector in bits 3:0 and the start-up selector in bits 7:4.
- R2: After reset, with the force-on parameter clear, `irq` and `sys_rst_req` are 0 and the control and period words read back their default values.
- R3: A control write that turns enable from 0 to 1 loads 2^(PERIOD_BASE+start-up selector). The first expiry, and its output, follows 2^(PERIOD_BASE+s)+1 clocks after that write's access edge.
- R4: A write whose low byte is 0x76 to offset 0x0C, with upper bits ignored, reloads 2^(PERIOD_BASE+running selector). The next expiry follows that many clocks plus one later. Offset 0x08 returns the live count.
- R5: A write to offset 0x0C whose low byte is not 0x76 leaves the count and the expiry time unchanged.
- R6: With mode bit 0, an expiry starts a `sys_rst_req` pulse in the next cycle and leaves `irq` low.
- R7: With mode bit 1, the first expiry sets `irq` (offset 0x10 bit 0 reads it) and reloads the running period. The following expiry starts a `sys_rst_req` pulse, even if the interrupt was cleared in between.
- R8: A key write clears `irq` and cancels the pending second stage, so the next expiry raises `irq` again instead of a reset.
- R9: A read of offset 0x14 clears `irq` without reloading the counter.
- R10: The reset-request pulse stays high for exactly 2^(p+1) clocks for each selector p from 0 to 7.
- R11: While `pause` is 1, the count holds and no expiry occurs. Counting resumes when `pause` returns to 0.
- R12: While disabled, the count holds and neither output is raised.
- R13: With the force-on parameter set, the watchdog is enabled from reset and counts from its start-up period. A write of 0 to control bit 0 leaves it enabled.
- R14: Writes to offsets 0x08, 0x10 and 0x14 change neither the count nor `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | 8 | APB byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| pause | input | 1 | Freezes the counter while high |
| irq | output | 1 | First-stage expiry interrupt |
| sys_rst_req | output | 1 | Reset request pulse |

## Verification
The bench sets PERIOD_BASE to 4 and the counter width to 16. Selector codes 0 to 4 then give periods of 16 to 256 clocks. This brings exact expiry timing within reach for several running and start-up selectors, and for every reset-pulse selector 0 to 7, with all times worked out arithmetically. A second instance is built with the force-on parameter set and with interrupt-first as its default mode, so the always-enabled path is exercised from reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned APB_AW = 8;
    localparam int unsigned APB_DW = 32;

    localparam logic [APB_AW-1:0] OFS_CTRL  = 8'h00;
    localparam logic [APB_AW-1:0] OFS_SPAN  = 8'h04;
    localparam logic [APB_AW-1:0] OFS_COUNT = 8'h08;
    localparam logic [APB_AW-1:0] OFS_KICK  = 8'h0C;
    localparam logic [APB_AW-1:0] OFS_STAT  = 8'h10;
    localparam logic [APB_AW-1:0] OFS_ACK   = 8'h14;

    localparam logic [7:0] KICK_KEY = 8'h76;

    typedef enum logic {
        RESP_RESET     = 1'b0,
        RESP_IRQ_FIRST = 1'b1
    } resp_mode_e;

    // packed MSB first: bits 4:2 pulse, bit 1 mode, bit 0 enable
    typedef struct packed {
        logic [2:0] pulse_sel;
        resp_mode_e mode;
        logic       enable;
    } ctrl_t;

    // bits 7:4 start-up selector, bits 3:0 running selector
    typedef struct packed {
        logic [3:0] init_sel;
        logic [3:0] run_sel;
    } span_t;

    typedef struct packed {
        logic arm;
        logic kick;
        logic ack;
    } evt_t;

    // last index of a pulse lasting 2^(sel+1) clocks
    function automatic logic [7:0] pulse_last(input logic [2:0] sel);
        logic [8:0] n;
        n = 9'd2 << sel;
        return 8'(n - 9'd1);
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W         = 32,
    parameter bit          ALWAYS_ON     = 1'b0,
    parameter bit          DFLT_MODE     = 1'b0,
    parameter logic [2:0]  DFLT_PULSE    = 3'd0,
    parameter logic [3:0]  DFLT_RUN_SEL  = 4'd0,
    parameter logic [3:0]  DFLT_INIT_SEL = 4'd0
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [APB_AW-1:0] paddr,
    input  logic [APB_DW-1:0] pwdata,
    output logic [APB_DW-1:0] prdata,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              irq_i,
    output ctrl_t             ctrl_o,
    output span_t             span_o,
    output evt_t              evt_o
);

    localparam int unsigned CTRL_W = $bits(ctrl_t);
    localparam int unsigned SPAN_W = $bits(span_t);

    ctrl_t ctrl_q;
    span_t span_q;
    logic  wr_acc, rd_acc, en_next;
    logic  unused_hi;

    assign wr_acc    = psel & penable & pwrite;
    assign rd_acc    = psel & penable & ~pwrite;
    assign en_next   = ALWAYS_ON ? 1'b1 : pwdata[0];
    assign unused_hi = ^pwdata[APB_DW-1:8];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{pulse_sel: DFLT_PULSE, mode: resp_mode_e'(DFLT_MODE), enable: ALWAYS_ON};
            span_q <= '{init_sel: DFLT_INIT_SEL, run_sel: DFLT_RUN_SEL};
        end else if (wr_acc && paddr == OFS_CTRL) begin
            ctrl_q <= '{pulse_sel: pwdata[4:2], mode: resp_mode_e'(pwdata[1]), enable: en_next};
        end else if (wr_acc && paddr == OFS_SPAN) begin
            span_q <= span_t'(pwdata[SPAN_W-1:0]);
        end
    end

    always_comb begin
        evt_o.arm  = wr_acc && paddr == OFS_CTRL && en_next && !ctrl_q.enable;
        evt_o.kick = wr_acc && paddr == OFS_KICK && pwdata[7:0] == KICK_KEY;
        evt_o.ack  = rd_acc && paddr == OFS_ACK;
    end

    always_comb begin
        case (paddr)
            OFS_CTRL:  prdata = {{(APB_DW-CTRL_W){1'b0}}, ctrl_q};
            OFS_SPAN:  prdata = {{(APB_DW-SPAN_W){1'b0}}, span_q};
            OFS_COUNT: prdata = APB_DW'(cnt_i);
            OFS_STAT:  prdata = {{(APB_DW-1){1'b0}}, irq_i};
            default:   prdata = '0;
        endcase
    end

    assign ctrl_o = ctrl_q;
    assign span_o = span_q;

    generate
        if (ALWAYS_ON) begin : g_forced_on
            // R13
            aon_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (wr_acc && paddr == OFS_CTRL && !pwdata[0]) |=> ctrl_q.enable);
        end
    endgenerate

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int unsigned CNT_W         = 32,
    parameter int unsigned PERIOD_BASE   = 16,
    parameter logic [3:0]  DFLT_INIT_SEL = 4'd0
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             pause,
    input  logic [3:0]       run_sel,
    input  logic [3:0]       init_sel,
    input  logic             arm,
    input  logic             kick,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);

    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
    localparam logic [CNT_W-1:0] RST_LEN = ONE << (PERIOD_BASE + int'(DFLT_INIT_SEL));

    logic [CNT_W-1:0] cnt_q, run_len, init_len;

    assign run_len  = ONE << (PERIOD_BASE + int'(run_sel));
    assign init_len = ONE << (PERIOD_BASE + int'(init_sel));
    assign expire_o = en && !pause && !kick && !arm && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= RST_LEN;
        end else if (arm) begin
            cnt_q <= init_len;
        end else if (kick || expire_o) begin
            cnt_q <= run_len;
        end else if (en && !pause) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign cnt_o = cnt_q;

    // R11
    pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pause && !arm && !kick) |=> (cnt_q == $past(cnt_q)));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !arm && !kick) |=> $stable(cnt_q));

    // R7
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        expire_o |=> (cnt_q == $past(run_len)));

endmodule

// File: rtl/wdt_response.sv
module wdt_response
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       expire,
    input  logic       kick,
    input  logic       ack,
    input  resp_mode_e mode,
    input  logic [2:0] pulse_sel,
    output logic       irq_o,
    output logic       rst_req_o
);

    logic       irq_q, stage_q, busy_q, fire;
    logic [7:0] left_q;

    assign fire = expire && (mode == RESP_RESET || stage_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q   <= 1'b0;
            stage_q <= 1'b0;
        end else if (kick) begin
            irq_q   <= 1'b0;
            stage_q <= 1'b0;
        end else if (fire) begin
            stage_q <= 1'b0;
        end else if (expire && mode == RESP_IRQ_FIRST) begin
            irq_q   <= 1'b1;
            stage_q <= 1'b1;
        end else if (ack) begin
            irq_q   <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            left_q <= '0;
        end else if (fire) begin
            busy_q <= 1'b1;
            left_q <= pulse_last(pulse_sel);
        end else if (busy_q) begin
            if (left_q == '0) busy_q <= 1'b0;
            else              left_q <= left_q - 8'd1;
        end
    end

    assign irq_o     = irq_q;
    assign rst_req_o = busy_q;

    // independent pulse-length tracker for the width check
    logic [8:0] hi_cnt, hi_exp;
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
            hi_exp <= '0;
        end else if (fire) begin
            hi_cnt <= '0;
            hi_exp <= 9'd2 << pulse_sel;
        end else if (busy_q) begin
            hi_cnt <= hi_cnt + 9'd1;
        end
    end

    // R6
    reset_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (expire && mode == RESP_RESET) |=> rst_req_o);

    // R7
    second_stage_chk: assert property (@(posedge clk) disable iff (rst)
        (expire && mode == RESP_IRQ_FIRST && stage_q) |=> rst_req_o);

    // R8
    kick_clear_chk: assert property (@(posedge clk) disable iff (rst)
        kick |=> !irq_o);

    // R9
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !expire && !kick) |=> !irq_o);

    // R10
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_req_o) |-> (hi_cnt == hi_exp));

endmodule

// File: rtl/wdt_apb.sv
module wdt_apb
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W         = 32,
    parameter int unsigned PERIOD_BASE   = 16,
    parameter bit          ALWAYS_ON     = 1'b0,
    parameter bit          DFLT_MODE     = 1'b0,
    parameter logic [2:0]  DFLT_PULSE    = 3'd0,
    parameter logic [3:0]  DFLT_RUN_SEL  = 4'd0,
    parameter logic [3:0]  DFLT_INIT_SEL = 4'd0
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [APB_AW-1:0] paddr,
    input  logic [APB_DW-1:0] pwdata,
    output logic [APB_DW-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              pause,
    output logic              irq,
    output logic              sys_rst_req
);

    ctrl_t            ctrl;
    span_t            span;
    evt_t             evt;
    logic [CNT_W-1:0] cnt;
    logic             expire;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    wdt_regs #(
        .CNT_W(CNT_W), .ALWAYS_ON(ALWAYS_ON), .DFLT_MODE(DFLT_MODE),
        .DFLT_PULSE(DFLT_PULSE), .DFLT_RUN_SEL(DFLT_RUN_SEL), .DFLT_INIT_SEL(DFLT_INIT_SEL)
    ) u_regs (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .cnt_i(cnt), .irq_i(irq),
        .ctrl_o(ctrl), .span_o(span), .evt_o(evt)
    );

    wdt_counter #(
        .CNT_W(CNT_W), .PERIOD_BASE(PERIOD_BASE), .DFLT_INIT_SEL(DFLT_INIT_SEL)
    ) u_counter (
        .clk(clk), .rst(rst), .en(ctrl.enable), .pause(pause),
        .run_sel(span.run_sel), .init_sel(span.init_sel),
        .arm(evt.arm), .kick(evt.kick), .cnt_o(cnt), .expire_o(expire)
    );

    wdt_response u_resp (
        .clk(clk), .rst(rst), .expire(expire), .kick(evt.kick), .ack(evt.ack),
        .mode(ctrl.mode), .pulse_sel(ctrl.pulse_sel),
        .irq_o(irq), .rst_req_o(sys_rst_req)
    );

endmodule

// File: tb/tb_wdt_apb.sv
module tb_wdt_apb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        psel_m = 0, psel_a = 0, penable = 0, pwrite = 0, pause = 0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata_m, prdata_a;
    logic        pready_m, pslverr_m, pready_a, pslverr_a;
    logic        irq_m, rst_m, irq_a, rst_a;

    int     total = 0, bad = 0;
    longint cyc = 0;
    bit     finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    wdt_apb #(.CNT_W(16), .PERIOD_BASE(4)) dut (
        .clk(clk), .rst(rst), .psel(psel_m), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata_m), .pready(pready_m),
        .pslverr(pslverr_m), .pause(pause), .irq(irq_m), .sys_rst_req(rst_m));

    wdt_apb #(.CNT_W(16), .PERIOD_BASE(4), .ALWAYS_ON(1'b1), .DFLT_MODE(1'b1),
              .DFLT_INIT_SEL(4'd1)) dut_aon (
        .clk(clk), .rst(rst), .psel(psel_a), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata_a), .pready(pready_a),
        .pslverr(pslverr_a), .pause(1'b0), .irq(irq_a), .sys_rst_req(rst_a));

    task automatic chk(input string tag, input longint got, input longint exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic wr(input bit aon, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel_m = !aon; psel_a = aon; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk);
        penable = 1;
        @(negedge clk);
        psel_m = 0; psel_a = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd(input bit aon, input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        psel_m = !aon; psel_a = aon; pwrite = 0; paddr = a; penable = 0;
        @(negedge clk);
        penable = 1;
        #1 d = aon ? prdata_a : prdata_m;
        @(negedge clk);
        psel_m = 0; psel_a = 0; penable = 0;
    endtask

    task automatic wait_out(input bit aon, input bit want_rst, output longint stamp);
        int n;
        n = 0;
        while (!(want_rst ? (aon ? rst_a : rst_m) : (aon ? irq_a : irq_m)) && n < 2000) begin
            @(negedge clk);
            n++;
        end
        stamp = cyc;
    endtask

    task automatic pulse_width(output int w);
        w = 0;
        while (rst_m && w < 1000) begin
            w++;
            @(negedge clk);
        end
    endtask

    // disable, then kick to clear interrupt and pending stage
    task automatic quiesce();
        wr(0, 8'h00, 32'h0);
        wr(0, 8'h0C, 32'h76);
    endtask

    function automatic longint span_len(input int sel);
        return longint'(1) << (4 + sel);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired got=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, a0, b0;
        longint s, t;
        int w;
        repeat (5) @(negedge clk);
        rst = 0;

        // R13 forced-on instance
        rd(1, 8'h00, d);
        chk("R13 enabled from reset", d, 32'h3);
        wr(1, 8'h00, 32'h2);
        rd(1, 8'h00, d);
        chk("R13 disable write ignored", d, 32'h3);
        wait_out(1, 0, s);
        chk("R13 counts from start-up period", irq_a, 1);

        // R2 reset state, R1 bus response
        chk("R2 irq at reset", irq_m, 0);
        chk("R2 reset request at reset", rst_m, 0);
        rd(0, 8'h00, d); chk("R2 ctrl default", d, 0);
        rd(0, 8'h04, d); chk("R2 span default", d, 0);
        chk("R1 pready", pready_m, 1);
        chk("R1 pslverr", pslverr_m, 0);
        wr(0, 8'h00, 32'h16);
        rd(0, 8'h00, d); chk("R1 ctrl readback", d, 32'h16);
        wr(0, 8'h04, 32'h21);
        rd(0, 8'h04, d); chk("R1 span readback", d, 32'h21);

        // R12 disabled holds
        rd(0, 8'h08, a0);
        repeat (40) @(negedge clk);
        rd(0, 8'h08, b0);
        chk("R12 count holds while disabled", b0, a0);
        chk("R12 no irq while disabled", irq_m, 0);
        chk("R12 no reset while disabled", rst_m, 0);

        // R3 start-up period sweep
        for (int m = 0; m < 3; m++) begin
            quiesce();
            wr(0, 8'h04, (m << 4) | 3);
            wr(0, 8'h00, 32'h3);
            s = cyc;
            wait_out(0, 0, t);
            chk($sformatf("R3 start-up expiry sel=%0d", m), t - s, span_len(m) + 1);
        end

        // R4 running period sweep, key with upper bits set
        for (int c = 0; c < 4; c++) begin
            quiesce();
            wr(0, 8'h04, (3 << 4) | c);
            wr(0, 8'h00, 32'h3);
            wr(0, 8'h0C, 32'hABCD_1276);
            s = cyc;
            rd(0, 8'h08, d);
            chk($sformatf("R4 live count sel=%0d", c), d, span_len(c) - 2);
            wait_out(0, 0, t);
            chk($sformatf("R4 kick expiry sel=%0d", c), t - s, span_len(c) + 1);
        end

        // R5 wrong key ignored
        quiesce();
        wr(0, 8'h04, 32'h00);
        wr(0, 8'h00, 32'h3);
        wr(0, 8'h0C, 32'h76);
        s = cyc;
        wr(0, 8'h0C, 32'h75);
        wr(0, 8'h0C, 32'h67);
        wait_out(0, 0, t);
        chk("R5 wrong key leaves expiry time", t - s, 17);

        // R7 and R9 two-stage response with ack between
        quiesce();
        wr(0, 8'h04, 32'h11);
        wr(0, 8'h00, 32'h0B);      // pulse sel 2, irq-first, enable
        wr(0, 8'h0C, 32'h76);
        s = cyc;
        wait_out(0, 0, t);
        chk("R7 first expiry raises irq", t - s, 33);
        chk("R7 no reset at first expiry", rst_m, 0);
        rd(0, 8'h10, d); chk("R7 status bit reads irq", d, 1);
        rd(0, 8'h08, a0);
        rd(0, 8'h14, d);
        rd(0, 8'h08, b0);
        chk("R9 ack clears irq", irq_m, 0);
        chk("R9 ack does not reload count", a0 - b0, 6);
        rd(0, 8'h10, d); chk("R9 status after ack", d, 0);
        wait_out(0, 1, t);
        chk("R7 second expiry resets despite ack", t - s, 66);
        pulse_width(w);
        chk("R10 pulse width sel=2", w, 8);
        chk("R7 irq stays low at second stage", irq_m, 0);

        // R8 kick cancels pending stage
        quiesce();
        wr(0, 8'h04, 32'h00);
        wr(0, 8'h00, 32'h3);
        wr(0, 8'h0C, 32'h76);
        wait_out(0, 0, t);
        wr(0, 8'h0C, 32'h76);
        s = cyc;
        chk("R8 kick clears irq", irq_m, 0);
        wait_out(0, 0, t);
        chk("R8 next expiry is irq timing", t - s, 17);
        chk("R8 next expiry no reset", rst_m, 0);

        // R6 and R10 reset mode, pulse length sweep
        for (int p = 0; p < 8; p++) begin
            quiesce();
            wr(0, 8'h04, 32'h00);
            wr(0, 8'h00, (p << 2) | 1);
            wr(0, 8'h0C, 32'h76);
            s = cyc;
            wait_out(0, 1, t);
            chk($sformatf("R6 reset timing sel=%0d", p), t - s, 17);
            fork
                pulse_width(w);
                wr(0, 8'h00, p << 2);
            join
            chk($sformatf("R10 pulse width sel=%0d", p), w, longint'(2) << p);
            chk($sformatf("R6 no irq in reset mode sel=%0d", p), irq_m, 0);
        end

        // R11 pause holds count and suppresses expiry
        quiesce();
        wr(0, 8'h04, 32'h00);
        wr(0, 8'h00, 32'h3);
        wr(0, 8'h0C, 32'h76);
        pause = 1;
        rd(0, 8'h08, a0);
        repeat (40) @(negedge clk);
        rd(0, 8'h08, b0);
        chk("R11 count at pause", a0, 16);
        chk("R11 count held during pause", b0, 16);
        chk("R11 no expiry during pause", irq_m, 0);
        pause = 0;
        s = cyc;
        wait_out(0, 0, t);
        chk("R11 resume timing", t - s, 17);

        // R14 writes to read-only offsets ignored
        pause = 1;
        rd(0, 8'h08, a0);
        wr(0, 8'h08, 32'h5);
        wr(0, 8'h10, 32'h0);
        wr(0, 8'h14, 32'h1);
        rd(0, 8'h08, b0);
        chk("R14 count unchanged by writes", b0, a0);
        chk("R14 irq unchanged by writes", irq_m, 1);
        pause = 0;
        quiesce();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule